// File: doc/BRIEF.md
# Multi-cycle multiply and multiply-accumulate unit

This block is the multiply engine beside the integer pipeline of a 32-bit core. A single-cycle start strobe hands it an operation code and two 32-bit operands. It captures them, stays busy for a latency that depends on the operation and on a contention flag sampled with the strobe, and then writes its result into a 64-bit accumulator. The accumulator is kept as two 32-bit halves: an upper half and a lower half. Both halves are always visible at the outputs.

Three forms write only the lower half: a 32x32 multiply that keeps the low 32 bits, and signed and unsigned 16x16 multiplies with a 32-bit product. Two forms add a signed product to the whole 64-bit value: a 16x16 product and a 32x32 product. Software-style side inputs clear both halves or load either half directly. These side inputs take precedence over a result written in the same cycle.

Top module: `mac_unit`

## Requirements
- R1: After synchronous reset, busy and done are 0 and both accumulator halves read 0.
- R2: Op code 0 (32x32 multiply) writes the low 32 bits of a*b into the lower half and leaves the upper half unchanged. Done rises 2 cycles after the start edge, or 4 cycles if contention was flagged.
- R3: Op code 1 (signed 16x16) sign-extends bits [15:0] of both operands and writes the 32-bit product to the lower half. The upper half is unchanged. Latency is 1 cycle, or 3 under contention.
- R4: Op code 2 (unsigned 16x16) zero-extends bits [15:0] of both operands and writes the 32-bit product to the lower half. The upper half is unchanged. Latency is 1 cycle, or 3 under contention.
- R5: Op code 3 (word accumulate) adds the sign-extended signed 16x16 product to the 64-bit {upper,lower} value, modulo 2^64. Latency is 3 cycles, or 2 under contention.
- R6: Op code 4 (long accumulate) adds the signed 32x32 64-bit product to {upper,lower}, modulo 2^64. Latency is 3 cycles, or 4 under contention.
- R7: Busy is 1 in every cycle from the cycle after an accepted start until the result is written. Done is a one-cycle pulse, and busy is 0 while done is 1.
- R8: A start strobe while busy is 1 is ignored: the running operation completes with its own operands, op and timing, and no extra done follows.
- R9: A clear input zeroes both halves at the next edge and overrides loads and results.
- R10: A load-upper or load-lower input writes the load data into that half at the next edge. When a result is written in the same cycle, the load wins for its half and the other half still takes the result.
- R11: A start with an op code from 5 to 7 is not accepted: busy stays 0, no done follows and the accumulator is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start strobe |
| op | input | 3 | Operation code (0..4 valid) |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| contend | input | 1 | Memory contention flag, sampled with start |
| acc_clr | input | 1 | Clear both accumulator halves |
| ld_hi | input | 1 | Load upper half from ld_data |
| ld_lo | input | 1 | Load lower half from ld_data |
| ld_data | input | 32 | Direct load value |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| acc_hi | output | 32 | Upper accumulator half |
| acc_lo | output | 32 | Lower accumulator half |

## Verification
A result write-back and a direct half load can fall in the same cycle. The bench provokes this by counting the issued operation's latency and raising a load so that it meets the completion edge exactly. It does this once for a 32x32 multiply with a lower-half load and once for a word accumulate with an upper-half load. The scoreboard expects the loaded half to hold the load data and the other half to hold the computed result. Overlapping start strobes during busy and invalid op codes are judged by the absence of any extra done pulse and by an unchanged accumulator.

// File: rtl/mac_pkg.sv
package mac_pkg;

    typedef enum logic [2:0] {
        OP_MUL32  = 3'd0,
        OP_MULS16 = 3'd1,
        OP_MULU16 = 3'd2,
        OP_MACW   = 3'd3,
        OP_MACL   = 3'd4
    } mop_e;

    typedef struct packed {
        mop_e        op;
        logic [31:0] a;
        logic [31:0] b;
    } job_t;

    function automatic logic op_valid(input logic [2:0] code);
        return code <= 3'd4;
    endfunction

    function automatic logic op_accum(input mop_e code);
        return (code == OP_MACW) || (code == OP_MACL);
    endfunction

    function automatic logic op_half(input mop_e code);
        return (code == OP_MULS16) || (code == OP_MULU16) || (code == OP_MACW);
    endfunction

    function automatic logic op_signed(input mop_e code);
        return code != OP_MULU16;
    endfunction

    function automatic int unsigned imax(input int unsigned x, input int unsigned y);
        return (x > y) ? x : y;
    endfunction

endpackage

// File: rtl/mac_seq.sv
module mac_seq
    import mac_pkg::*;
#(
    parameter int unsigned LAT_M32   = 2,
    parameter int unsigned LAT_M32_C = 4,
    parameter int unsigned LAT_M16   = 1,
    parameter int unsigned LAT_M16_C = 3,
    parameter int unsigned LAT_MW    = 3,
    parameter int unsigned LAT_MW_C  = 2,
    parameter int unsigned LAT_ML    = 3,
    parameter int unsigned LAT_ML_C  = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [2:0] op,
    input  logic       contend,
    output logic       accept,
    output logic       fire,
    output logic       busy,
    output logic       done
);
    localparam int unsigned LMAX = imax(imax(imax(LAT_M32, LAT_M32_C), imax(LAT_M16, LAT_M16_C)),
                                        imax(imax(LAT_MW, LAT_MW_C), imax(LAT_ML, LAT_ML_C)));
    localparam int unsigned CW   = $clog2(LMAX + 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] lat_sel;
    logic          busy_q;
    logic          done_q;

    always_comb begin
        unique case (op)
            3'd0:    lat_sel = CW'(contend ? LAT_M32_C : LAT_M32);
            3'd1,
            3'd2:    lat_sel = CW'(contend ? LAT_M16_C : LAT_M16);
            3'd3:    lat_sel = CW'(contend ? LAT_MW_C : LAT_MW);
            3'd4:    lat_sel = CW'(contend ? LAT_ML_C : LAT_ML);
            default: lat_sel = '0;
        endcase
    end

    assign accept = start && !busy_q && op_valid(op);
    assign fire   = busy_q && (cnt_q == CW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= fire;
            if (accept) begin
                cnt_q  <= lat_sel;
                busy_q <= 1'b1;
            end else if (busy_q) begin
                cnt_q  <= cnt_q - CW'(1);
                if (fire) busy_q <= 1'b0;
            end
        end
    end

    assign busy = busy_q;
    assign done = done_q;

endmodule

// File: rtl/mac_opnd.sv
module mac_opnd
    import mac_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        accept,
    input  logic [2:0]  op,
    input  logic [31:0] a,
    input  logic [31:0] b,
    output job_t        job
);
    job_t job_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            job_q <= '{op: OP_MUL32, a: '0, b: '0};
        end else if (accept) begin
            job_q.op <= mop_e'(op);
            job_q.a  <= a;
            job_q.b  <= b;
        end
    end

    assign job = job_q;

endmodule

// File: rtl/mac_prod.sv
module mac_prod
    import mac_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  mop_e            op,
    input  logic [DW-1:0]   a,
    input  logic [DW-1:0]   b,
    output logic [2*DW-1:0] prod
);
    localparam int unsigned HW = DW / 2;

    logic signed [DW:0]     a_ext;
    logic signed [DW:0]     b_ext;
    logic signed [2*DW+1:0] full;

    function automatic logic [DW:0] widen(input logic [DW-1:0] v, input logic half,
                                          input logic sgn);
        logic [DW:0] r;
        if (half)
            r = {{(DW+1-HW){sgn & v[HW-1]}}, v[HW-1:0]};
        else
            r = {sgn & v[DW-1], v};
        return r;
    endfunction

    always_comb begin
        a_ext = widen(a, op_half(op), op_signed(op));
        b_ext = widen(b, op_half(op), op_signed(op));
        full  = a_ext * b_ext;
        prod  = full[2*DW-1:0];
    end

endmodule

// File: rtl/mac_acc.sv
module mac_acc
    import mac_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          ld_hi,
    input  logic          ld_lo,
    input  logic [DW-1:0] ld_data,
    input  logic          wr,
    input  logic          accum,
    input  logic [2*DW-1:0] prod,
    output logic [DW-1:0] hi,
    output logic [DW-1:0] lo
);
    logic [DW-1:0]   hi_q, lo_q;
    logic [2*DW-1:0] sum;
    logic [DW-1:0]   hi_n, lo_n;

    always_comb begin
        sum  = {hi_q, lo_q} + prod;
        hi_n = hi_q;
        lo_n = lo_q;
        if (wr) begin
            lo_n = accum ? sum[DW-1:0] : prod[DW-1:0];
            if (accum) hi_n = sum[2*DW-1:DW];
        end
        if (ld_hi) hi_n = ld_data;
        if (ld_lo) lo_n = ld_data;
        if (clr) begin
            hi_n = '0;
            lo_n = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q <= '0;
            lo_q <= '0;
        end else begin
            hi_q <= hi_n;
            lo_q <= lo_n;
        end
    end

    assign hi = hi_q;
    assign lo = lo_q;

endmodule

// File: rtl/mac_unit.sv
module mac_unit
    import mac_pkg::*;
#(
    parameter int unsigned DW        = 32,
    parameter int unsigned LAT_M32   = 2,
    parameter int unsigned LAT_M32_C = 4,
    parameter int unsigned LAT_M16   = 1,
    parameter int unsigned LAT_M16_C = 3,
    parameter int unsigned LAT_MW    = 3,
    parameter int unsigned LAT_MW_C  = 2,
    parameter int unsigned LAT_ML    = 3,
    parameter int unsigned LAT_ML_C  = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [2:0]    op,
    input  logic [DW-1:0] opnd_a,
    input  logic [DW-1:0] opnd_b,
    input  logic          contend,
    input  logic          acc_clr,
    input  logic          ld_hi,
    input  logic          ld_lo,
    input  logic [DW-1:0] ld_data,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] acc_hi,
    output logic [DW-1:0] acc_lo
);
    logic            accept;
    logic            fire;
    job_t            job;
    logic [2*DW-1:0] prod;
    mop_e            op_q;

    mac_seq #(
        .LAT_M32(LAT_M32), .LAT_M32_C(LAT_M32_C),
        .LAT_M16(LAT_M16), .LAT_M16_C(LAT_M16_C),
        .LAT_MW(LAT_MW),   .LAT_MW_C(LAT_MW_C),
        .LAT_ML(LAT_ML),   .LAT_ML_C(LAT_ML_C)
    ) u_seq (
        .clk(clk), .rst(rst), .start(start), .op(op), .contend(contend),
        .accept(accept), .fire(fire), .busy(busy), .done(done)
    );

    mac_opnd u_opnd (
        .clk(clk), .rst(rst), .accept(accept), .op(op),
        .a(opnd_a), .b(opnd_b), .job(job)
    );

    assign op_q = job.op;

    mac_prod #(.DW(DW)) u_prod (
        .op(op_q), .a(job.a), .b(job.b), .prod(prod)
    );

    mac_acc #(.DW(DW)) u_acc (
        .clk(clk), .rst(rst), .clr(acc_clr), .ld_hi(ld_hi), .ld_lo(ld_lo),
        .ld_data(ld_data), .wr(fire), .accum(op_accum(op_q)), .prod(prod),
        .hi(acc_hi), .lo(acc_lo)
    );

endmodule

// File: rtl/mac_unit_chk.sv
module mac_unit_chk
    import mac_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic [2:0]    op,
    input logic          acc_clr,
    input logic          ld_hi,
    input logic          ld_lo,
    input logic [DW-1:0] ld_data,
    input logic          busy,
    input logic          done,
    input logic [DW-1:0] acc_hi,
    input logic [DW-1:0] acc_lo,
    input mop_e          job_op
);
    p_done_idle_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_busy_after_start_r7: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && op_valid(op)) |=> busy);

    p_bad_op_r11: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && !op_valid(op)) |=> !busy);

    p_start_ignored_r8: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(job_op));

    p_clear_r9: assert property (@(posedge clk) disable iff (rst)
        acc_clr |=> (acc_hi == '0 && acc_lo == '0));

    p_load_hi_r10: assert property (@(posedge clk) disable iff (rst)
        (ld_hi && !acc_clr) |=> acc_hi == $past(ld_data));

    p_load_lo_r10: assert property (@(posedge clk) disable iff (rst)
        (ld_lo && !acc_clr) |=> acc_lo == $past(ld_data));

    p_hi_kept_r2: assert property (@(posedge clk) disable iff (rst)
        (busy && !op_accum(job_op) && !ld_hi && !acc_clr) |=> $stable(acc_hi));

endmodule

bind mac_unit mac_unit_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst(rst), .start(start), .op(op), .acc_clr(acc_clr),
    .ld_hi(ld_hi), .ld_lo(ld_lo), .ld_data(ld_data), .busy(busy),
    .done(done), .acc_hi(acc_hi), .acc_lo(acc_lo), .job_op(op_q)
);

// File: tb/tb_mac_unit.sv
module tb_mac_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [2:0]  op = 3'd0;
    logic [31:0] opnd_a = '0, opnd_b = '0;
    logic        contend = 1'b0;
    logic        acc_clr = 1'b0, ld_hi = 1'b0, ld_lo = 1'b0;
    logic [31:0] ld_data = '0;
    logic        busy, done;
    logic [31:0] acc_hi, acc_lo;

    always #2 clk = ~clk;

    mac_unit dut (
        .clk(clk), .rst(rst), .start(start), .op(op), .opnd_a(opnd_a),
        .opnd_b(opnd_b), .contend(contend), .acc_clr(acc_clr), .ld_hi(ld_hi),
        .ld_lo(ld_lo), .ld_data(ld_data), .busy(busy), .done(done),
        .acc_hi(acc_hi), .acc_lo(acc_lo)
    );

    int n_cmp = 0, n_bad = 0, cyc = 0;
    bit finished = 0;
    logic [63:0] model = '0;

    typedef struct {
        logic [63:0] acc;
        int          lat;
        int          t0;
        string       tag;
    } item_t;
    item_t sb[$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int lat_of(input int o, input bit c);
        case (o)
            0: return c ? 4 : 2;
            1, 2: return c ? 3 : 1;
            3: return c ? 2 : 3;
            default: return c ? 4 : 3;
        endcase
    endfunction

    function automatic logic [63:0] calc(input int o, input logic [31:0] a,
                                         input logic [31:0] b, input logic [63:0] acc);
        logic [63:0] r;
        longint sa, sb2;
        r = acc;
        case (o)
            0: r[31:0] = a * b;
            1: begin
                sa = longint'($signed(a[15:0])); sb2 = longint'($signed(b[15:0]));
                r[31:0] = 32'(sa * sb2);
            end
            2: r[31:0] = {16'b0, a[15:0]} * {16'b0, b[15:0]};
            3: begin
                sa = longint'($signed(a[15:0])); sb2 = longint'($signed(b[15:0]));
                r = acc + 64'(sa * sb2);
            end
            default: begin
                sa = longint'($signed(a)); sb2 = longint'($signed(b));
                r = acc + 64'(sa * sb2);
            end
        endcase
        return r;
    endfunction

    // monitor: pops on every done pulse
    always @(negedge clk) begin
        if (!rst && done) begin
            if (sb.size() == 0) begin
                check("R8/R11 unexpected done", 64'd1, 64'd0);
            end else begin
                item_t it;
                it = sb.pop_front();
                check({it.tag, " latency"}, 64'(cyc - it.t0 - 1), 64'(it.lat));
                check({it.tag, " accumulator"}, {acc_hi, acc_lo}, it.acc);
                check("R7 busy low with done", 64'(busy), 64'd0);
            end
        end
    end

    // ldk: 0 none, 1 lower-half load at completion, 2 upper-half load at completion
    task automatic issue(input int o, input logic [31:0] a, input logic [31:0] b,
                         input bit c, input string tag, input int ldk = 0,
                         input logic [31:0] ldv = '0, input bit dbl = 0);
        item_t it;
        int n;
        n = lat_of(o, c);
        it.acc = calc(o, a, b, model);
        if (ldk == 1) it.acc[31:0] = ldv;
        if (ldk == 2) it.acc[63:32] = ldv;
        @(negedge clk);
        start = 1'b1; op = 3'(o); opnd_a = a; opnd_b = b; contend = c;
        it.lat = n; it.t0 = cyc; it.tag = tag;
        sb.push_back(it);
        model = it.acc;
        @(negedge clk);
        if (dbl) begin
            op = 3'd1; opnd_a = ~a; opnd_b = 32'h7; contend = 1'b0;
        end else begin
            start = 1'b0;
        end
        check("R7 busy after start", 64'(busy), 64'd1);
        if (dbl) begin
            @(negedge clk);
            start = 1'b0;
            if (ldk != 0) repeat (n - 2) @(negedge clk);
        end else if (ldk != 0) begin
            repeat (n - 1) @(negedge clk);
        end
        if (ldk != 0) begin
            ld_data = ldv;
            if (ldk == 1) ld_lo = 1'b1; else ld_hi = 1'b1;
            @(negedge clk);
            ld_lo = 1'b0; ld_hi = 1'b0;
        end
        wait (sb.size() == 0);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset busy/done", {62'd0, busy, done}, 64'd0);
        check("R1 reset accumulator", {acc_hi, acc_lo}, 64'd0);

        // R10 direct loads
        ld_hi = 1'b1; ld_data = 32'hA5A5_0001;
        @(negedge clk); ld_hi = 1'b0; ld_lo = 1'b1; ld_data = 32'h1234_5678;
        @(negedge clk); ld_lo = 1'b0;
        model = 64'hA5A5_0001_1234_5678;
        check("R10 direct loads", {acc_hi, acc_lo}, model);

        issue(0, 32'h1234_5678, 32'h9ABC_DEF1, 0, "R2 mul32");
        issue(0, 32'hFFFF_FFFF, 32'hFFFF_FFFE, 1, "R2 mul32 contention");
        issue(1, 32'hABCD_8001, 32'h0000_7FFF, 0, "R3 signed16");
        issue(1, 32'h0000_FFFE, 32'h1111_FFFD, 1, "R3 signed16 contention");
        issue(2, 32'h0000_FFFE, 32'h2222_FFFD, 0, "R4 unsigned16");
        issue(2, 32'hFFFF_8000, 32'h0000_8000, 1, "R4 unsigned16 contention");
        issue(3, 32'h0000_8000, 32'h0000_7FFF, 0, "R5 word accumulate");
        issue(3, 32'h5555_FFFF, 32'h0000_0003, 1, "R5 word accumulate contention");
        issue(4, 32'h8000_0000, 32'h8000_0000, 0, "R6 long accumulate");
        issue(4, 32'hFFFF_FFF0, 32'h0123_4567, 1, "R6 long accumulate contention");

        // R9 clear overrides a simultaneous load
        acc_clr = 1'b1; ld_hi = 1'b1; ld_data = 32'hDEAD_BEEF;
        @(negedge clk); acc_clr = 1'b0; ld_hi = 1'b0;
        model = '0;
        check("R9 clear", {acc_hi, acc_lo}, 64'd0);

        issue(4, 32'hFFFF_FFFF, 32'h0000_0005, 0, "R6 accumulate negative");
        // R8 start held while busy
        issue(4, 32'h0000_1000, 32'h0003_0000, 0, "R8 start while busy", 0, '0, 1);
        repeat (5) @(negedge clk);
        check("R8 no further activity", {63'd0, busy}, 64'd0);

        // R10 collisions with result write-back
        issue(0, 32'h0000_0100, 32'h0000_0300, 0, "R10 mul32 with lower load", 1, 32'hCAFE_F00D);
        issue(3, 32'h0000_0002, 32'h0000_0003, 0, "R10 word acc with upper load", 2, 32'h0BAD_0BAD);

        // R11 invalid op code
        @(negedge clk);
        start = 1'b1; op = 3'd6; opnd_a = 32'h7; opnd_b = 32'h9;
        @(negedge clk); start = 1'b0;
        check("R11 invalid op not busy", 64'(busy), 64'd0);
        repeat (5) @(negedge clk);
        check("R11 invalid op accumulator", {acc_hi, acc_lo}, model);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule